// File: doc/BRIEF.md
# Presettable Cascadable Binary Counter

This block is a synchronous up-counter whose state bits all change together on the rising clock edge. It can be preset from a parallel data bus and cleared to zero. It has two count enables. `en_p` only qualifies counting. `en_t` qualifies counting and also gates the terminal-count output `carry`.

Several copies chain into a wider synchronous counter with no extra logic. Each stage's `carry` drives the next stage's `en_t`, and all stages share `en_p`, `load_n`, `clr_n` and `clk`.

A parameter selects the clear style:
- Immediate (asynchronous): an active-low clear forces zero at once.
- Clocked (synchronous): an active-low clear forces zero at the next edge.

The active-low clear doubles as the block's reset.

Top module: `preset_bin_counter`

## Requirements
- R1: All `WIDTH` state bits are registered and change only on a rising edge of `clk`, all in the same edge, apart from an immediate clear.
- R2: When `load_n` is 0 and `clr_n` is 1 at a rising edge, `q` takes the value of `din`, whatever the levels of `en_p` and `en_t`.
- R3: When `clr_n` and `load_n` are both 1 at a rising edge, `q` increments by one if `en_p` and `en_t` are both 1, and otherwise keeps its value.
- R4: An increment from the all-ones value (15 when `WIDTH` is 4) gives 0.
- R5: `carry` is 1 exactly when `en_t` is 1 and `q` is all ones. It is combinational and follows `en_t` without a clock edge.
- R6: With `ASYNC_CLEAR` = 1, a 0 on `clr_n` forces `q` to 0 at once, with no clock edge. `q` stays 0 while `clr_n` is 0, whatever the clock, load and enable inputs do.
- R7: With `ASYNC_CLEAR` = 0, a 0 on `clr_n` sets `q` to 0 at the next rising edge. Before that edge `q` does not change.
- R8: The priority at an edge is clear first, then load, then count. When `clr_n` and `load_n` are both 0, the result is 0.
- R9: Changes on `en_p`, `en_t` or `load_n` between clock edges leave `q` unchanged.
- R10: Three stages chained as described above, with `carry` of stage k driving `en_t` of stage k+1, count as one 12-bit binary value. The most significant stage's `carry` is 1 exactly when all 12 bits are ones and the first stage's `en_t` is 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| clr_n | input | 1 | Active-low clear, immediate or clocked per `ASYNC_CLEAR` |
| load_n | input | 1 | Active-low parallel preset |
| en_p | input | 1 | Count enable that does not reach `carry` |
| en_t | input | 1 | Count enable that also gates `carry` |
| din | input | WIDTH | Preset data |
| q | output | WIDTH | Counter state |
| carry | output | 1 | Terminal count: `en_t` AND `q` all ones |

## Verification
The bench builds a three-stage chain in clocked-clear mode and a single stage in immediate-clear mode, and drives both against a behavioural 12-bit model.

It goes after the following corner cases:
- **Wrap through every stage (0xFFF to 0x000).** A stage that leaves `en_t` out of its count enable would over-count in the upper nibbles. One that leaves it out of `carry` would raise the upper carries early.
- **Clear and load together.** These must give zero, so a design with the priority reversed shows the preset data instead.
- **Load with both enables low.** A design that gated the load with the enables would keep its old value.
- **Mid-cycle probes.** The bench checks `q` between edges. A clocked clear that acted at once fails this probe, and so does an immediate clear that waited for the edge.
- **`en_t` toggled while `q` is all ones.** This shows whether `carry` tracks `en_t` combinationally.

// File: rtl/pbc_pkg.sv
package pbc_pkg;
   typedef enum logic [1:0] {
      OP_HOLD  = 2'd0,
      OP_INC   = 2'd1,
      OP_LOAD  = 2'd2,
      OP_CLEAR = 2'd3
   } pbc_op_e;
endpackage

// File: rtl/pbc_mode_sel.sv
module pbc_mode_sel
   import pbc_pkg::*;
#(
   parameter bit SYNC_CLEAR = 1'b1
) (
   input  logic    clr_n,
   input  logic    load_n,
   input  logic    en_p,
   input  logic    en_t,
   output pbc_op_e op
);
   logic clear_req;

   generate
      if (SYNC_CLEAR) begin : g_clr_sync
         assign clear_req = ~clr_n;
      end else begin : g_clr_async
         // Immediate clear acts on the flops directly, not via this selector.
         assign clear_req = 1'b0;
      end
   endgenerate

   // Priority: clear, then load, then count.
   always_comb begin
      if (clear_req)          op = OP_CLEAR;
      else if (!load_n)       op = OP_LOAD;
      else if (en_p && en_t)  op = OP_INC;
      else                    op = OP_HOLD;
   end
endmodule

// File: rtl/pbc_next_value.sv
module pbc_next_value
   import pbc_pkg::*;
#(
   parameter int WIDTH = 4
) (
   input  pbc_op_e          op,
   input  logic [WIDTH-1:0] cur,
   input  logic [WIDTH-1:0] din,
   output logic [WIDTH-1:0] nxt
);
   localparam logic [WIDTH-1:0] ONE = WIDTH'(1);

   logic [WIDTH-1:0] incr;
   assign incr = cur + ONE;   // wraps from all ones to zero

   always_comb begin
      unique case (op)
         OP_CLEAR: nxt = '0;
         OP_LOAD:  nxt = din;
         OP_INC:   nxt = incr;
         default:  nxt = cur;
      endcase
   end
endmodule

// File: rtl/pbc_state_reg.sv
module pbc_state_reg #(
   parameter int WIDTH        = 4,
   parameter bit ASYNC_CLEAR  = 1'b1
) (
   input  logic             clk,
   input  logic             clr_n,
   input  logic [WIDTH-1:0] nxt,
   output logic [WIDTH-1:0] q
);
   generate
      if (ASYNC_CLEAR) begin : g_async
         always_ff @(posedge clk or negedge clr_n) begin
            if (!clr_n) q <= '0;
            else        q <= nxt;
         end

         // R6: while clear is held, the state reads zero at every edge
         a_r6_async_clear_zero: assert property (@(posedge clk)
            !clr_n |-> q == '0)
            else $error("R6: state not zero under immediate clear");
      end else begin : g_sync
         always_ff @(posedge clk) begin
            q <= nxt;
         end

         // R7: clear sampled at an edge yields zero after that edge
         a_r7_sync_clear_zero: assert property (@(posedge clk)
            !clr_n |=> q == '0)
            else $error("R7: clocked clear did not zero the state");
      end
   endgenerate
endmodule

// File: rtl/pbc_terminal.sv
module pbc_terminal #(
   parameter int WIDTH = 4
) (
   input  logic [WIDTH-1:0] q,
   input  logic             en_t,
   output logic             carry
);
   logic all_ones;
   assign all_ones = &q;
   assign carry    = en_t & all_ones;
endmodule

// File: rtl/preset_bin_counter.sv
module preset_bin_counter
   import pbc_pkg::*;
#(
   parameter int WIDTH       = 4,
   parameter bit ASYNC_CLEAR = 1'b1
) (
   input  logic             clk,
   input  logic             clr_n,
   input  logic             load_n,
   input  logic             en_p,
   input  logic             en_t,
   input  logic [WIDTH-1:0] din,
   output logic [WIDTH-1:0] q,
   output logic             carry
);
   localparam bit               SYNC_CLEAR = !ASYNC_CLEAR;
   localparam logic [WIDTH-1:0] ONE        = WIDTH'(1);

   generate
      if (WIDTH < 1) begin : g_bad_width
         $error("preset_bin_counter: WIDTH must be at least 1");
      end
   endgenerate

   pbc_op_e          op;
   logic [WIDTH-1:0] nxt;

   pbc_mode_sel #(.SYNC_CLEAR(SYNC_CLEAR)) u_sel (
      .clr_n  (clr_n),
      .load_n (load_n),
      .en_p   (en_p),
      .en_t   (en_t),
      .op     (op)
   );

   pbc_next_value #(.WIDTH(WIDTH)) u_next (
      .op  (op),
      .cur (q),
      .din (din),
      .nxt (nxt)
   );

   pbc_state_reg #(.WIDTH(WIDTH), .ASYNC_CLEAR(ASYNC_CLEAR)) u_reg (
      .clk   (clk),
      .clr_n (clr_n),
      .nxt   (nxt),
      .q     (q)
   );

   pbc_terminal #(.WIDTH(WIDTH)) u_term (
      .q     (q),
      .en_t  (en_t),
      .carry (carry)
   );

   // R2: preset takes effect at the next edge regardless of the enables
   a_r2_load_takes_din: assert property (@(posedge clk) disable iff (!clr_n)
      !load_n |=> q == $past(din))
      else $error("R2: load did not capture din");

   // R3: both enables high -> increment by one
   a_r3_count_step: assert property (@(posedge clk) disable iff (!clr_n)
      (load_n && en_p && en_t) |=> q == WIDTH'($past(q) + ONE))
      else $error("R3: count step wrong");

   // R3: either enable low -> state held
   a_r3_hold_when_disabled: assert property (@(posedge clk) disable iff (!clr_n)
      (load_n && !(en_p && en_t)) |=> $stable(q))
      else $error("R3: state moved while disabled");

   // R4: all ones plus one gives zero
   a_r4_wrap_to_zero: assert property (@(posedge clk) disable iff (!clr_n)
      (load_n && en_p && en_t && (&q)) |=> q == '0)
      else $error("R4: no wrap to zero");

   // R5: carry never high without en_t
   a_r5_carry_needs_t: assert property (@(posedge clk) disable iff (!clr_n)
      carry |-> (en_t && (&q)))
      else $error("R5: carry high outside terminal count");
endmodule

// File: tb/tb_preset_bin_counter.sv
`timescale 1ns/1ps
module tb_preset_bin_counter;
   logic        clk = 1'b0;
   always #5 clk = ~clk;

   logic        clr_n, clra_n, load_n, en_p, en_t;
   logic [11:0] din;
   logic [3:0]  q0, q1, q2, qa;
   logic        c0, c1, c2, ca;

   // Three-stage chain, clocked clear
   preset_bin_counter #(.WIDTH(4), .ASYNC_CLEAR(1'b0)) dut (
      .clk(clk), .clr_n(clr_n), .load_n(load_n), .en_p(en_p), .en_t(en_t),
      .din(din[3:0]), .q(q0), .carry(c0));
   preset_bin_counter #(.WIDTH(4), .ASYNC_CLEAR(1'b0)) u_mid (
      .clk(clk), .clr_n(clr_n), .load_n(load_n), .en_p(en_p), .en_t(c0),
      .din(din[7:4]), .q(q1), .carry(c1));
   preset_bin_counter #(.WIDTH(4), .ASYNC_CLEAR(1'b0)) u_top (
      .clk(clk), .clr_n(clr_n), .load_n(load_n), .en_p(en_p), .en_t(c1),
      .din(din[11:8]), .q(q2), .carry(c2));
   // Single stage, immediate clear
   preset_bin_counter #(.WIDTH(4), .ASYNC_CLEAR(1'b1)) u_async (
      .clk(clk), .clr_n(clra_n), .load_n(load_n), .en_p(en_p), .en_t(en_t),
      .din(din[3:0]), .q(qa), .carry(ca));

   int compared = 0;
   int mismatched = 0;
   int m12;   // chain model
   int ma;    // single-stage model
   bit valid = 0;
   bit done  = 0;

   task automatic chk(input string req, input int act, input int exp);
      compared++;
      if (act !== exp) begin
         mismatched++;
         $display("FAIL %s: actual %0h expected %0h at %0t", req, act, exp, $time);
      end
   endtask

   task automatic compare_all(input string req);
      logic et;
      et = en_t;
      chk({req, " R10 chain value"}, {q2, q1, q0}, m12);
      chk({req, " R5 c0"}, c0, int'(et && (m12 & 12'h00F) == 12'h00F));
      chk({req, " R5 c1"}, c1, int'(et && (m12 & 12'h0FF) == 12'h0FF));
      chk({req, " R10 c2"}, c2, int'(et && m12 == 12'hFFF));
      chk({req, " R1 single value"}, qa, ma);
      chk({req, " R5 single carry"}, ca, int'(et && ma == 15));
   endtask

   // Apply inputs just after a falling edge, probe before the rising edge,
   // update the model at the edge, compare after the next falling edge.
   task automatic step(input string req, input logic clr, input logic clra,
                       input logic ld, input logic p, input logic t,
                       input logic [11:0] d);
      clr_n = clr; clra_n = clra; load_n = ld; en_p = p; en_t = t; din = d;
      #1;
      if (valid) begin
         // R9 / R7: no edge yet, so chain state unchanged
         chk({req, " R9 R7 pre-edge chain"}, {q2, q1, q0}, m12);
         // R6: immediate clear visible before the edge
         chk({req, " R6 R9 pre-edge single"}, qa, clra ? ma : 0);
         if (!clra) ma = 0;
      end
      @(posedge clk);
      if (!clr)          m12 = 0;
      else if (!ld)      m12 = d;
      else if (p && t)   m12 = (m12 + 1) % 4096;
      if (!clra)         ma = 0;
      else if (!ld)      ma = d[3:0];
      else if (p && t)   ma = (ma + 1) % 16;
      valid = 1;
      @(negedge clk);
      #1;
      compare_all(req);
   endtask

   initial begin
      #2_000_000;
      if (!done) begin
         mismatched++;
         $display("FAIL watchdog: actual hung expected finish");
         $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
         $finish;
      end
   end

   initial begin
      clr_n = 0; clra_n = 0; load_n = 1; en_p = 0; en_t = 0; din = '0;
      m12 = 0; ma = 0;
      @(negedge clk);
      // Reset state through clear
      step("R7 R6 reset", 0, 0, 1, 1, 1, 12'h000);
      step("R7 R6 reset", 0, 0, 1, 1, 1, 12'h000);
      // Plain counting
      for (int i = 0; i < 20; i++) step("R3 count", 1, 1, 1, 1, 1, 12'h000);
      // Wrap of the whole chain
      step("R2 load near top", 1, 1, 0, 1, 1, 12'hFFD);
      for (int i = 0; i < 5; i++) step("R4 R10 wrap", 1, 1, 1, 1, 1, 12'h000);
      // Enables individually low
      step("R3 p low", 1, 1, 1, 0, 1, 12'h000);
      step("R3 t low", 1, 1, 1, 1, 0, 12'h000);
      // Carry follows en_t without a clock
      step("R2 load ones", 1, 1, 0, 1, 0, 12'hFFF);
      step("R5 t low at top", 1, 1, 1, 1, 0, 12'h000);
      step("R5 t high at top", 1, 1, 1, 0, 1, 12'h000);
      // Load with both enables low
      step("R2 load disabled", 1, 1, 0, 0, 0, 12'h5A3);
      // Clear beats load
      step("R8 clear over load", 0, 0, 0, 1, 1, 12'h777);
      // Stage-boundary carries
      step("R2 load", 1, 1, 0, 0, 0, 12'h0EE);
      for (int i = 0; i < 20; i++) step("R10 nibble carry", 1, 1, 1, 1, 1, 12'h000);
      // Immediate clear only on single stage, with load requested
      step("R6 R8 async clear", 1, 0, 0, 1, 1, 12'h00A);
      step("R6 async hold", 1, 0, 1, 1, 1, 12'h000);
      step("R3 resume", 1, 1, 1, 1, 1, 12'h000);
      // Weighted random traffic
      for (int i = 0; i < 400; i++) begin
         logic c, ca_n, l, p, t;
         c    = ($urandom_range(0, 99) >= 3);
         ca_n = ($urandom_range(0, 99) >= 3);
         l    = ($urandom_range(0, 99) >= 8);
         p    = ($urandom_range(0, 99) < 85);
         t    = ($urandom_range(0, 99) < 85);
         step("R1 R8 random", c, ca_n, l, p, t, 12'($urandom_range(0, 4095)));
      end
      done = 1;
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
   end
endmodule